// File: doc/BRIEF.md
# Instruction Format and Addressing-Mode Decoder

This block is a purely combinational front-end decoder for a 16-bit instruction word of a microcoded processor with memory-to-memory operands. It classifies each word by its two most significant bits as zero-operand, one-operand, two-operand or branch. It also splits the word into its opcode, mode, steering bit and two register fields.

From the 3-bit mode field it derives the addressing type: register, immediate, indexed or PC-relative. It reports whether indirection applies, or whether the word instead names direct addressing, which is the indirect form of the immediate type. It tells the sequencer whether a second instruction word must be fetched and which operand, source or destination, the addressing mode applies to. It also flags combinations that have no meaning. Address arithmetic and memory access stay with the datapath that consumes these outputs.

Top module: `instr_fmt_decode`

## Requirements
- R1: The fields are taken from fixed positions of `instr`. The class is bits 15:14 (00 zero-operand, 01 one-operand, 10 two-operand, 11 branch). The opcode is bits 15:10, mode is bits 9:7, the steering bit is bit 6, the source register is bits 5:3 and the destination register is bits 2:0.
- R2: For class 00, `addr_kind` is 00 and `use_indirect`, `is_direct`, `need_ext_word`, `mode_on_dst` and `illegal` are all 0, whatever the low bits hold.
- R3: For classes 01, 10 and 11, `addr_kind` equals mode bits 2:1. The encoding is 00 register, 01 immediate, 10 indexed, 11 PC-relative.
- R4: For the register, indexed and PC-relative kinds in classes 01, 10 and 11, `use_indirect` equals mode bit 0 and `is_direct` is 0.
- R5: For the immediate kind with mode bit 0 set, `is_direct` is 1 and `use_indirect` is 0. With mode bit 0 clear, both are 0.
- R6: `need_ext_word` is 1 exactly when the class is 01, 10 or 11 and `addr_kind` is not register.
- R7: `mode_on_dst` is 1 for classes 01 and 11. For class 10 it equals the steering bit (0 means the mode applies to the source).
- R8: A branch (class 11) in register mode (mode bits 2:1 = 00) raises `illegal`.
- R9: A two-operand word with the steering bit set and plain immediate mode (mode = 010) raises `illegal`, since a literal cannot be a destination.
- R10: `illegal` is 0 for every word not covered by R8 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word under decode |
| fmt_class | output | 2 | Operand class |
| opcode | output | 6 | Opcode field |
| mode | output | 3 | Raw mode field |
| steer | output | 1 | Steering bit |
| src_reg | output | 3 | Source register field |
| dst_reg | output | 3 | Destination register field |
| addr_kind | output | 2 | Addressing type |
| use_indirect | output | 1 | Generated address is a pointer |
| is_direct | output | 1 | Second word is the operand address |
| need_ext_word | output | 1 | A second instruction word must be fetched |
| mode_on_dst | output | 1 | Addressing mode applies to the destination |
| illegal | output | 1 | Meaningless field combination |

## Verification
The assertions check only relations among the outputs for a settled input word. They assume `instr` is a full 16-bit value with no unknown bits, and that it changes only between sampling points. The bench keeps to this by driving `instr` once on each falling clock edge and sampling shortly afterwards. A table of hand-derived vectors covers every class and mode pair that matters. A sweep over all 65536 words then checks each field position and the flags against a model written from the requirements.

// File: rtl/instr_fmt_decode.sv
module instr_fmt_decode #(
  parameter int REG_W = 3,
  parameter int OPC_W = 6
) (
  input  logic [OPC_W+4+2*REG_W-1:0] instr,
  output logic [1:0]                 fmt_class,
  output logic [OPC_W-1:0]           opcode,
  output logic [2:0]                 mode,
  output logic                       steer,
  output logic [REG_W-1:0]           src_reg,
  output logic [REG_W-1:0]           dst_reg,
  output logic [1:0]                 addr_kind,
  output logic                       use_indirect,
  output logic                       is_direct,
  output logic                       need_ext_word,
  output logic                       mode_on_dst,
  output logic                       illegal
);
  localparam int IW     = OPC_W + 4 + 2*REG_W;
  localparam int S_POS  = 2*REG_W;
  localparam int M_LO   = S_POS + 1;

  localparam logic [1:0] C_NONE = 2'b00;
  localparam logic [1:0] C_ONE  = 2'b01;
  localparam logic [1:0] C_TWO  = 2'b10;
  localparam logic [1:0] C_BR   = 2'b11;
  localparam logic [1:0] K_REG  = 2'b00;
  localparam logic [1:0] K_IMM  = 2'b01;

  logic has_opnd;
  logic ind_bit;

  assign fmt_class = instr[IW-1 -: 2];
  assign opcode    = instr[IW-1 -: OPC_W];
  assign mode      = instr[M_LO+2 -: 3];
  assign steer     = instr[S_POS];
  assign src_reg   = instr[S_POS-1 -: REG_W];
  assign dst_reg   = instr[REG_W-1:0];

  assign has_opnd  = (fmt_class != C_NONE);
  assign ind_bit   = has_opnd & mode[0];
  assign addr_kind = has_opnd ? mode[2:1] : K_REG;

  assign is_direct     = ind_bit & (addr_kind == K_IMM);
  assign use_indirect  = ind_bit & (addr_kind != K_IMM);
  assign need_ext_word = has_opnd & (addr_kind != K_REG);

  always_comb begin
    unique case (fmt_class)
      C_ONE:   mode_on_dst = 1'b1;
      C_TWO:   mode_on_dst = steer;
      C_BR:    mode_on_dst = 1'b1;
      default: mode_on_dst = 1'b0;
    endcase
  end

  assign illegal = ((fmt_class == C_BR) && (mode[2:1] == K_REG)) ||
                   ((fmt_class == C_TWO) && steer && (mode == 3'b010));

  always_comb begin
    p_zero_class_quiet_r2: assert (fmt_class != C_NONE ||
      (!need_ext_word && !use_indirect && !is_direct && !mode_on_dst && !illegal))
      else $error("zero-operand class produced an active flag");
    p_reg_no_word_r6: assert (addr_kind != K_REG || !need_ext_word)
      else $error("register kind requested a second word");
    p_direct_excl_r5: assert (!(is_direct && use_indirect))
      else $error("direct and indirect both set");
    p_branch_reg_bad_r8: assert (!(fmt_class == C_BR && addr_kind == K_REG) || illegal)
      else $error("branch in register mode not flagged");
    p_illegal_scope_r10: assert (!illegal || fmt_class[1])
      else $error("illegal raised outside two-operand or branch class");
  end
endmodule

// File: tb/tb_instr_fmt_decode.sv
module tb_instr_fmt_decode;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] instr;
  logic [1:0]  fmt_class, addr_kind;
  logic [5:0]  opcode;
  logic [2:0]  mode, src_reg, dst_reg;
  logic        steer, use_indirect, is_direct, need_ext_word, mode_on_dst, illegal;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  instr_fmt_decode dut (
    .instr(instr), .fmt_class(fmt_class), .opcode(opcode), .mode(mode),
    .steer(steer), .src_reg(src_reg), .dst_reg(dst_reg), .addr_kind(addr_kind),
    .use_indirect(use_indirect), .is_direct(is_direct),
    .need_ext_word(need_ext_word), .mode_on_dst(mode_on_dst), .illegal(illegal)
  );

  // flag pack: {illegal, mode_on_dst, need_ext_word, is_direct, use_indirect, addr_kind}
  function automatic logic [6:0] flags_now();
    return {illegal, mode_on_dst, need_ext_word, is_direct, use_indirect, addr_kind};
  endfunction

  localparam int NV = 19;
  localparam logic [22:0] VEC [NV] = '{
    {16'b00_0101_111_1_010_011, 7'b0000000},  // R2
    {16'b00_0000_000_0_000_000, 7'b0000000},  // R2
    {16'b01_0010_000_0_000_101, 7'b0100000},  // R3 R7
    {16'b01_0011_001_0_110_001, 7'b0100100},  // R4
    {16'b01_0001_010_0_000_010, 7'b0110001},  // R5 R6
    {16'b01_0001_011_0_000_010, 7'b0111001},  // R5
    {16'b10_0000_100_0_001_010, 7'b0010010},  // R4 R7
    {16'b10_0000_101_1_001_010, 7'b0110110},  // R4 R7
    {16'b10_1100_110_0_011_100, 7'b0010011},  // R3
    {16'b10_1100_111_1_011_100, 7'b0110111},  // R4
    {16'b10_0110_010_1_101_110, 7'b1110001},  // R9
    {16'b10_0110_010_0_101_110, 7'b0010001},  // R10
    {16'b10_0110_011_1_101_110, 7'b0111001},  // R5 R10
    {16'b10_0001_000_1_111_111, 7'b0100000},  // R6 R10
    {16'b10_0001_001_0_111_111, 7'b0000100},  // R4
    {16'b11_0000_000_0_000_011, 7'b1100000},  // R8
    {16'b11_0000_001_0_000_011, 7'b1100100},  // R8
    {16'b11_1010_010_0_000_011, 7'b0110001},  // R10
    {16'b11_1010_111_1_000_011, 7'b0110111}   // R3 R4
  };

  function automatic logic [6:0] model(input logic [15:0] w);
    logic [1:0] c = w[15:14];
    logic [2:0] m = w[9:7];
    logic       op = (c != 2'b00);
    logic [1:0] k = op ? m[2:1] : 2'b00;
    logic dir = op && k == 2'b01 && m[0];
    logic ind = op && k != 2'b01 && m[0];
    logic nw  = op && k != 2'b00;
    logic md  = (c == 2'b10) ? w[6] : op;
    logic il  = (c == 2'b11 && m[2:1] == 2'b00) || (c == 2'b10 && w[6] && m == 3'b010);
    return {il, md, nw, dir, ind, k};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s instr=%b actual=%0h expected=%0h", req, instr, act, exp);
    end
  endtask

  initial begin
    instr = 16'h0000;
    @(negedge clk); #2;
    chk("R2 idle", {25'd0, flags_now()}, 32'd0);

    foreach (VEC[i]) begin
      @(negedge clk);
      instr = VEC[i][22:7];
      #2;
      chk("R2-table", {25'd0, flags_now()}, {25'd0, VEC[i][6:0]});
      chk("R1 class", {30'd0, fmt_class}, {30'd0, VEC[i][22:21]});
    end

    for (int w = 0; w < 65536; w++) begin
      @(negedge clk);
      instr = w[15:0];
      #2;
      chk("R1 fields", {9'd0, fmt_class, opcode, mode, steer, src_reg, dst_reg},
          {9'd0, instr[15:14], instr[15:10], instr[9:7], instr[6], instr[5:3], instr[2:0]});
      chk("R3 R4 R5 R6 R7 R8 R9 R10 sweep", {25'd0, flags_now()}, {25'd0, model(instr)});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule